// File: doc/BRIEF.md
# I2C Interrupt Flag, Mask and Vector Unit

This block collects the one-cycle event pulses that an I2C bus engine raises during a transfer: lost arbitration, a missing acknowledge, register access ready, receive data ready, transmit data ready, stop seen on the bus and a match on the slave address. Each pulse sets a sticky flag. Software reads the flags through a 16-bit status register and clears them by writing ones. A mask register selects which flags may raise the single interrupt request line.

A vector register gives an interrupt handler a short path. Each read returns a 3-bit code for the most urgent pending source that is enabled. The code is zero when nothing is pending, so a handler can read repeatedly until it gets zero. For the one-shot event sources, the read also clears the reported flag. The two data-ready flags behave like levels: they clear only when the data itself is moved. That means a read at the receive data offset, or a write at the transmit data offset. The status register also shows two live levels from the bus engine: receive shift register full and bus busy.

The register port uses plain strobes and has no back-pressure. A write is accepted in the cycle its strobe is high. A read is accepted in the cycle its strobe is high, and its data appears on the read bus after the next clock edge. The read bus then holds that value until the next read.

Top module: `i2c_irq_vec`

## Requirements
- R1: After reset, all seven flags and the mask register are 0, the interrupt request is low, and the vector register reads 0.
- R2: A pulse on event input bit k sets flag k, which shows as status bit k. The flag stays set until it is cleared. The bit order is: lost arbitration 0, no-acknowledge 1, access ready 2, receive ready 3, transmit ready 4, stop detected 5, addressed as slave 6.
- R3: Writing the status register (offset 0x08) with a 1 in bit k clears flag k, and a 0 leaves it unchanged. An event pulse in the same cycle as a clear of the same flag wins, so the flag stays set.
- R4: The mask register (offset 0x04) stores write data bits 6:0 at the same positions as the flags. Its bits 15:7 read as 0.
- R5: The interrupt request is high exactly when some flag and its mask bit are both 1. It follows a flag change one cycle after the causing edge.
- R6: The vector register (offset 0x28) returns k+1 for the lowest bit position k whose flag and mask bit are both 1. It returns 0 when no such bit exists. Pending flags whose mask bit is 0 are ignored.
- R7: A vector read clears the flag it reports when that flag is at bit 0, 1, 2, 5 or 6. It leaves receive ready (bit 3) and transmit ready (bit 4) set.
- R8: A read at offset 0x18 clears the receive ready flag. A write at offset 0x20 clears the transmit ready flag.
- R9: Status bit 11 shows the receive shift full input and bit 12 shows the bus busy input. Writes have no effect on either bit.
- R10: Read data appears on the read bus one cycle after the read strobe. It holds its value in cycles with no read, even if the flags change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse_i | input | 7 | One-cycle event pulses from the bus engine, bit order as in R2 |
| rx_full_i | input | 1 | Receive shift register full level |
| bus_busy_i | input | 1 | Bus busy level |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default values: seven sources, a 16-bit data word and an 8-bit offset. With seven sources, the bench can sweep every combination of pending flags against every mask value, all 128 × 128 of them. For each pair it computes the expected request, the expected vector code and the flags left after the vector read, and compares them with the design. Directed sequences cover the remaining cases. These are: a set and a clear of the same flag in one cycle, the two data-offset clears, the live status levels, and the read bus holding its value.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

  // Source positions: these fix priority (lower wins) and vector code (pos+1)
  localparam int SRC_ARB   = 0;
  localparam int SRC_NOACK = 1;
  localparam int SRC_ACCR  = 2;
  localparam int SRC_RXRDY = 3;
  localparam int SRC_TXRDY = 4;
  localparam int SRC_STOP  = 5;
  localparam int SRC_SLV   = 6;
  localparam int NSRC      = 7;

  // Sources that a vector read must not clear (data-ready levels)
  localparam logic [NSRC-1:0] LEVEL_SRC = (NSRC'(1) << SRC_RXRDY) | (NSRC'(1) << SRC_TXRDY);

  typedef struct packed {
    logic [NSRC-1:0] by_write;
    logic [NSRC-1:0] by_vector;
    logic [NSRC-1:0] by_data;
  } clr_req_t;

endpackage

// File: rtl/i2c_irq_flags.sv
module i2c_irq_flags #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);

  logic [N-1:0] flag_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q[g] <= 1'b0;
      else if (set_i[g]) flag_q[g] <= 1'b1;
      else if (clr_i[g]) flag_q[g] <= 1'b0;
    end

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_q[g]); // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !clr_i[g]) |=> flag_q[g]); // R2
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flag_q[g]); // R3
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/i2c_irq_prio.sv
module i2c_irq_prio #(
  parameter int N  = 7,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  req_i,
  output logic [CW-1:0] code_o,
  output logic [N-1:0]  hit_o
);

  always_comb begin
    code_o = '0;
    hit_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        code_o   = CW'(i + 1);
        hit_o    = '0;
        hit_o[i] = 1'b1;
      end
    end
  end

  always_comb begin
    AST_HIT_ONEHOT: assert ($onehot0(hit_o)); // R6
  end

endmodule

// File: rtl/i2c_irq_regif.sv
module i2c_irq_regif
  import i2c_irq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 8,
  parameter int CW       = 3,
  parameter int OFS_MASK = 'h04,
  parameter int OFS_STAT = 'h08,
  parameter int OFS_RXD  = 'h18,
  parameter int OFS_TXD  = 'h20,
  parameter int OFS_VEC  = 'h28,
  parameter int RSF_BIT  = 11,
  parameter int BB_BIT   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSRC-1:0]   flag_i,
  input  logic [CW-1:0]     code_i,
  input  logic [NSRC-1:0]   hit_i,
  input  logic              rx_full_i,
  input  logic              bus_busy_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NSRC-1:0]   mask_o,
  output clr_req_t          clr_o
);

  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_RXD  = ADDR_W'(OFS_RXD);
  localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(OFS_TXD);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(OFS_VEC);

  logic sel_mask, sel_stat, sel_rxd, sel_txd, sel_vec;
  logic [NSRC-1:0]   mask_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] stat_word;

  always_comb begin
    sel_mask = (addr_i == A_MASK);
    sel_stat = (addr_i == A_STAT);
    sel_rxd  = (addr_i == A_RXD);
    sel_txd  = (addr_i == A_TXD);
    sel_vec  = (addr_i == A_VEC);
  end

  always_comb begin
    stat_word             = '0;
    stat_word[NSRC-1:0]   = flag_i;
    stat_word[RSF_BIT]    = rx_full_i;
    stat_word[BB_BIT]     = bus_busy_i;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_mask)     rd_mux = DATA_W'(mask_q);
    else if (sel_stat) rd_mux = stat_word;
    else if (sel_vec)  rd_mux = DATA_W'(code_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    mask_q <= '0;
    else if (wr_en_i && sel_mask)  mask_q <= wdata_i[NSRC-1:0];
  end

  always_comb begin
    clr_o.by_write  = (wr_en_i && sel_stat) ? wdata_i[NSRC-1:0] : '0;
    clr_o.by_vector = (rd_en_i && sel_vec) ? (hit_i & ~LEVEL_SRC) : '0;
    clr_o.by_data   = '0;
    clr_o.by_data[SRC_RXRDY] = rd_en_i && sel_rxd;
    clr_o.by_data[SRC_TXRDY] = wr_en_i && sel_txd;
  end

  assign rdata_o = rdata_q;
  assign mask_o  = mask_q;

  AST_MASK_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && sel_mask) |=> (mask_q == $past(wdata_i[NSRC-1:0]))); // R4
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_q)); // R10

endmodule

// File: rtl/i2c_irq_vec.sv
module i2c_irq_vec
  import i2c_irq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 8,
  parameter int OFS_MASK = 'h04,
  parameter int OFS_STAT = 'h08,
  parameter int OFS_RXD  = 'h18,
  parameter int OFS_TXD  = 'h20,
  parameter int OFS_VEC  = 'h28,
  parameter int RSF_BIT  = 11,
  parameter int BB_BIT   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        evt_pulse_i,
  input  logic              rx_full_i,
  input  logic              bus_busy_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  localparam int CW = $clog2(NSRC + 1);

  logic [NSRC-1:0] flags, mask, pend, hit, clr_all;
  logic [CW-1:0]   code;
  clr_req_t        clr;

  assign clr_all = clr.by_write | clr.by_vector | clr.by_data;

  i2c_irq_flags #(.N(NSRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt_pulse_i),
    .clr_i  (clr_all),
    .flag_o (flags)
  );

  assign pend = flags & mask;

  i2c_irq_prio #(.N(NSRC), .CW(CW)) u_prio (
    .req_i  (pend),
    .code_o (code),
    .hit_o  (hit)
  );

  i2c_irq_regif #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CW(CW),
    .OFS_MASK(OFS_MASK), .OFS_STAT(OFS_STAT), .OFS_RXD(OFS_RXD),
    .OFS_TXD(OFS_TXD), .OFS_VEC(OFS_VEC), .RSF_BIT(RSF_BIT), .BB_BIT(BB_BIT)
  ) u_regif (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .flag_i     (flags),
    .code_i     (code),
    .hit_i      (hit),
    .rx_full_i  (rx_full_i),
    .bus_busy_i (bus_busy_i),
    .rdata_o    (rdata_o),
    .mask_o     (mask),
    .clr_o      (clr)
  );

  assign irq_o = |pend;

  AST_IRQ_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (code != '0)); // R5
  AST_NO_CODE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0) |-> !irq_o); // R6
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    code <= CW'(NSRC)); // R6
  AST_LEVEL_SURVIVES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[SRC_RXRDY] && !clr.by_write[SRC_RXRDY] && !clr.by_data[SRC_RXRDY])
      |=> flags[SRC_RXRDY]); // R7

endmodule

// File: tb/sim_i2c_irq_vec.sv
module sim_i2c_irq_vec;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt = '0;
  logic        rx_full = 1'b0, busy = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_irq_vec u0 (
    .clk(clk), .rst_n(rst_n), .evt_pulse_i(evt), .rx_full_i(rx_full),
    .bus_busy_i(busy), .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [6:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  function automatic int exp_code(input int f, input int m);
    for (int i = 0; i < 7; i++)
      if (((f & m) >> i) & 1) return i + 1;
    return 0;
  endfunction

  initial begin
    logic [15:0] d, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq == 1'b0, "R1 irq", irq, 0);
    do_rd(8'h04, d); chk(d == 16'h0, "R1 mask", d, 0);
    do_rd(8'h28, d); chk(d == 16'h0, "R1 vector", d, 0);
    do_rd(8'h08, d); chk(d == 16'h0, "R1 status", d, 0);

    // R4 mask width
    do_wr(8'h04, 16'hFFFF);
    do_rd(8'h04, d); chk(d == 16'h007F, "R4 mask upper zero", d, 16'h7F);
    do_wr(8'h04, 16'h0000);

    // R9 level bits
    rx_full = 1'b1;
    do_rd(8'h08, d); chk(d == 16'h0800, "R9 rsfull bit11", d, 16'h0800);
    busy = 1'b1;
    do_rd(8'h08, d); chk(d == 16'h1800, "R9 busy bit12", d, 16'h1800);
    do_wr(8'h08, 16'hFFFF);
    do_rd(8'h08, d); chk(d == 16'h1800, "R9 write no effect", d, 16'h1800);
    rx_full = 1'b0; busy = 1'b0;

    // R2 / R3 set and W1C
    pulse(7'h7F);
    do_rd(8'h08, d); chk(d == 16'h007F, "R2 all flags set", d, 16'h7F);
    do_wr(8'h08, 16'h0000);
    do_rd(8'h08, d); chk(d == 16'h007F, "R3 write zero keeps", d, 16'h7F);
    do_wr(8'h08, 16'h0005);
    do_rd(8'h08, d); chk(d == 16'h007A, "R3 w1c bits0,2", d, 16'h7A);
    @(negedge clk); evt = 7'h01; addr = 8'h08; wdata = 16'h0001; wr_en = 1'b1;
    @(negedge clk); evt = '0; wr_en = 1'b0;
    do_rd(8'h08, d); chk(d == 16'h007B, "R3 set wins over clear", d, 16'h7B);
    do_wr(8'h08, 16'h007F);
    do_rd(8'h08, d); chk(d == 16'h0000, "R3 clear all", d, 0);

    // R7 / R8 data-ready flags
    do_wr(8'h04, 16'h007F);
    pulse(7'h18);
    do_rd(8'h28, d); chk(d == 16'd4, "R6 rx ready code", d, 4);
    do_rd(8'h08, d); chk(d == 16'h0018, "R7 level kept on vector read", d, 16'h18);
    do_rd(8'h18, d);
    do_rd(8'h08, d); chk(d == 16'h0010, "R8 rx data read clears", d, 16'h10);
    do_rd(8'h28, d); chk(d == 16'd5, "R6 tx ready code", d, 5);
    do_wr(8'h20, 16'h00A5);
    do_rd(8'h08, d); chk(d == 16'h0000, "R8 tx data write clears", d, 0);
    chk(irq == 1'b0, "R5 irq low after clears", irq, 0);

    // R10 read data holds
    pulse(7'h20);
    do_rd(8'h08, held);
    pulse(7'h01);
    repeat (3) @(negedge clk);
    chk(rdata == held, "R10 rdata holds", rdata, held);
    chk(irq == 1'b1, "R5 irq high", irq, 1);
    do_wr(8'h08, 16'h007F);

    // R5 R6 R7 exhaustive sweep of flags x mask
    for (int f = 0; f < 128; f++) begin
      for (int m = 0; m < 128; m++) begin
        int c, ef;
        c = exp_code(f, m);
        ef = f;
        if (c != 0 && c != 4 && c != 5) ef = f & ~(1 << (c - 1));
        pulse(7'(f));
        do_wr(8'h04, 16'(m));
        chk(irq == ((f & m) != 0), "R5 irq sweep", irq, ((f & m) != 0));
        do_rd(8'h28, d); chk(d == 16'(c), "R6 vector sweep", d, c);
        do_rd(8'h08, d); chk(d == 16'(ef), "R7 status after vector", d, ef);
        do_wr(8'h08, 16'h007F);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0x0 exp=0x1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule